// File: doc/BRIEF.md
# I2C Single-Master Command Controller

This block drives an I2C bus as its only master. Software issues one operation at a time: a start condition (also used as a repeated start), a stop condition, a byte write, a byte read, or a single acknowledge bit. Each operation ends with its own one-cycle completion pulse, so software builds a transaction step by step. It sends the address byte, or the two bytes of a 10-bit address, with ordinary writes. SCL and SDA are open-drain. Each line has an output enable, where 1 pulls the line low, and an input that reads the wired level back.

Bit timing comes from an external `tick` strobe. Each bus operation moves through four tick-paced phases. After the controller releases SCL, it waits until SCL reads back high before it goes on. A slave that holds SCL low therefore stretches the clock for as long as it needs. Received bytes land in a one-byte holding register. If a new byte completes while the previous one is still unread, the controller raises a receive error pulse.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset both line enables are 0 (lines released), and `busy`, `rx_valid`, `nak_seen`, `done_irq` and `rxerr_irq` are 0.
- R2: Op code 1 (start) releases SDA, releases SCL, pulls SDA low while SCL is high, and then pulls SCL low. `done_irq` is high for exactly one cycle when it finishes.
- R3: Op code 2 (stop) pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high. Both lines end released, and `done_irq` pulses once.
- R4: Op code 3 (write) clocks out the 8 bits of `cmd_data`. The order is most significant bit first when `lsb_first`=0 and least significant bit first when it is 1, sampled with the command. SDA changes only while SCL is low, so no start or stop condition appears during the byte.
- R5: On the ninth clock of a write, the controller releases SDA and samples it. `nak_seen` becomes 1 if SDA was high and 0 if it was low. One `done_irq` follows that ninth clock.
- R6: Op code 4 (read) gives 8 clocks with SDA released and assembles the sampled bits in the selected order. It then loads `rx_data`, sets `rx_valid` and pulses `done_irq`.
- R7: Op code 5 (acknowledge) gives one clock with SDA held low when `ack_nak`=0 and SDA released when `ack_nak`=1, then pulses `done_irq`.
- R8: While SCL is held low by another device after the controller released it, the operation makes no progress and `done_irq` stays low. The operation resumes once SCL reads high.
- R9: `rx_read` clears `rx_valid`. A read that completes while `rx_valid` is still 1 replaces `rx_data` and pulses `rxerr_irq` for one cycle.
- R10: A command is ignored, with no bus activity and no completion, if it arrives while `busy` is 1 or if its op code is 0, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-phase timing strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Op code: 1 start, 2 stop, 3 write, 4 read, 5 acknowledge |
| cmd_data | input | 8 | Byte for a write |
| ack_nak | input | 1 | Acknowledge value: 0 ACK, 1 NAK |
| lsb_first | input | 1 | Bit order for write/read |
| rx_read | input | 1 | Software has taken the received byte |
| busy | output | 1 | An operation is in progress |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte not yet taken |
| nak_seen | output | 1 | Last write got a NAK |
| done_irq | output | 1 | Operation complete pulse |
| rxerr_irq | output | 1 | Receive overrun pulse |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | SCL level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA level |

## Verification
A bus model on the bench counts start and stop conditions and records SDA at every SCL rising edge. If a design moved SDA while SCL is high during a byte, the model would count a spurious start or stop. A reversed bit order would show up as a mirrored captured byte. The bench holds SCL low through a whole acknowledge phase. A design that ignored stretching would then finish early, or clock bits while the line is still low. The bench also lets a read finish on top of an unread byte, and issues a stop while a repeated start is still running. A design without overrun detection would stay silent in the first case, and one that accepted commands while busy would put a stop on the bus in the second.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_START = 3'd1,
        OP_STOP  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4,
        OP_ACK   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        PR_START = 2'd0,
        PR_STOP  = 2'd1,
        PR_BIT   = 2'd2
    } prim_e;
endpackage

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift,
    input  logic          lsb_first,
    input  logic          in_bit,
    output logic          out_bit,
    output logic [DW-1:0] shifted
);
    logic [DW-1:0] sh_d, sh_q;

    always_comb begin
        shifted = lsb_first ? {in_bit, sh_q[DW-1:1]} : {sh_q[DW-2:0], in_bit};
        out_bit = lsb_first ? sh_q[0] : sh_q[DW-1];
        sh_d    = sh_q;
        if (load)
            sh_d = load_val;
        else if (shift)
            sh_d = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
    import i2cm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  req,
    input  prim_e kind,
    input  logic  bit_out,
    input  logic  scl_in,
    input  logic  sda_in,
    output logic  scl_oe,
    output logic  sda_oe,
    output logic  bit_in,
    output logic  done
);
    // phase 0: set SDA lead value, 3: release SCL, 1: wait SCL high, 2: pull SCL low
    typedef struct packed {
        logic       act;
        prim_e      kind;
        logic [1:0] phase;
        logic       bit_v;
        logic       scl_oe;
        logic       sda_oe;
        logic       bit_in;
        logic       done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.act) begin
            if (req) begin
                eng_d.act   = 1'b1;
                eng_d.kind  = kind;
                eng_d.phase = 2'd0;
                eng_d.bit_v = bit_out;
                if (kind != PR_START) eng_d.scl_oe = 1'b1;
            end
        end else if (tick) begin
            case (eng_q.phase)
                2'd0: begin
                    case (eng_q.kind)
                        PR_START: eng_d.sda_oe = 1'b0;
                        PR_STOP:  eng_d.sda_oe = 1'b1;
                        default:  eng_d.sda_oe = !eng_q.bit_v;
                    endcase
                    eng_d.phase = 2'd3;
                end
                2'd3: begin
                    eng_d.scl_oe = 1'b0;
                    eng_d.phase  = 2'd1;
                end
                2'd1: begin
                    if (scl_in) begin
                        case (eng_q.kind)
                            PR_START: begin
                                eng_d.sda_oe = 1'b1;
                                eng_d.phase  = 2'd2;
                            end
                            PR_STOP: begin
                                eng_d.sda_oe = 1'b0;
                                eng_d.act    = 1'b0;
                                eng_d.done   = 1'b1;
                            end
                            default: begin
                                eng_d.bit_in = sda_in;
                                eng_d.phase  = 2'd2;
                            end
                        endcase
                    end
                end
                default: begin
                    eng_d.scl_oe = 1'b1;
                    eng_d.act    = 1'b0;
                    eng_d.done   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign scl_oe = eng_q.scl_oe;
    assign sda_oe = eng_q.sda_oe;
    assign bit_in = eng_q.bit_in;
    assign done   = eng_q.done;

    AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.act && eng_q.phase == 2'd1 && !scl_in)
        |=> ($stable(scl_oe) && $stable(sda_oe) && !done)); // R8

    AST_DATA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.act && eng_q.kind == PR_BIT && !$stable(sda_oe)) |-> scl_oe); // R4
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    input  logic          ack_nak,
    input  logic          lsb_first,
    input  logic          rx_read,
    output logic          busy,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          nak_seen,
    output logic          done_irq,
    output logic          rxerr_irq,
    output logic          scl_oe,
    input  logic          scl_in,
    output logic          sda_oe,
    input  logic          sda_in
);
    localparam int CW = $clog2(DW + 2);
    localparam logic [CW-1:0] CNT_DATA = CW'(DW);
    localparam logic [CW-1:0] CNT_ACK  = CW'(DW + 1);

    typedef struct packed {
        logic          busy;
        logic [2:0]    op;
        logic [CW-1:0] cnt;
        logic          issue;
        logic          ack;
        logic          lsb;
        logic [DW-1:0] rx;
        logic          rx_full;
        logic          nak;
        logic          done;
        logic          rxerr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          eng_done, eng_bit_in, eng_bit;
    prim_e         eng_kind;
    logic          sh_load, sh_shift, sh_out;
    logic [DW-1:0] sh_next;
    logic          op_ok;
    logic [CW-1:0] cnt_nx;

    assign op_ok  = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
    assign cnt_nx = ctl_q.cnt + 1'b1;

    always_comb begin
        case (ctl_q.op)
            OP_START: eng_kind = PR_START;
            OP_STOP:  eng_kind = PR_STOP;
            default:  eng_kind = PR_BIT;
        endcase
        if (ctl_q.op == OP_WRITE && ctl_q.cnt < CNT_DATA) eng_bit = sh_out;
        else if (ctl_q.op == OP_ACK)                      eng_bit = ctl_q.ack;
        else                                              eng_bit = 1'b1;
        sh_load  = !ctl_q.busy && cmd_valid && cmd_op == OP_WRITE;
        sh_shift = ctl_q.busy && eng_done && ctl_q.cnt < CNT_DATA &&
                   (ctl_q.op == OP_WRITE || ctl_q.op == OP_READ);
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.rxerr = 1'b0;
        ctl_d.issue = 1'b0;
        if (rx_read) ctl_d.rx_full = 1'b0;
        if (!ctl_q.busy) begin
            if (cmd_valid && op_ok) begin
                ctl_d.busy  = 1'b1;
                ctl_d.op    = cmd_op;
                ctl_d.cnt   = '0;
                ctl_d.issue = 1'b1;
                ctl_d.ack   = ack_nak;
                ctl_d.lsb   = lsb_first;
            end
        end else if (eng_done) begin
            ctl_d.cnt = cnt_nx;
            case (ctl_q.op)
                OP_WRITE: begin
                    if (cnt_nx == CNT_ACK) begin
                        ctl_d.nak  = eng_bit_in;
                        ctl_d.busy = 1'b0;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.issue = 1'b1;
                    end
                end
                OP_READ: begin
                    if (cnt_nx == CNT_DATA) begin
                        ctl_d.rx      = sh_next;
                        ctl_d.rxerr   = ctl_q.rx_full && !rx_read;
                        ctl_d.rx_full = 1'b1;
                        ctl_d.busy    = 1'b0;
                        ctl_d.done    = 1'b1;
                    end else begin
                        ctl_d.issue = 1'b1;
                    end
                end
                default: begin
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    i2cm_shifter #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (cmd_data),
        .shift    (sh_shift),
        .lsb_first(ctl_q.lsb),
        .in_bit   (eng_bit_in),
        .out_bit  (sh_out),
        .shifted  (sh_next)
    );

    i2cm_bit_engine u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .req    (ctl_q.issue),
        .kind   (eng_kind),
        .bit_out(eng_bit),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe),
        .bit_in (eng_bit_in),
        .done   (eng_done)
    );

    assign busy      = ctl_q.busy;
    assign rx_data   = ctl_q.rx;
    assign rx_valid  = ctl_q.rx_full;
    assign nak_seen  = ctl_q.nak;
    assign done_irq  = ctl_q.done;
    assign rxerr_irq = ctl_q.rxerr;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R2

    AST_RXERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rxerr_irq |-> (rx_valid && done_irq)); // R9

    AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !op_ok) |=> !busy); // R10

    AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_irq && $past(busy)) |-> $stable(ctl_q.op)); // R10
endmodule

// File: tb/tb_i2cm_ctrl.sv
module tb_i2cm_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_data = '0;
    logic       ack_nak = 1'b0;
    logic       lsb_first = 1'b0;
    logic       rx_read = 1'b0;
    logic       busy, rx_valid, nak_seen, done_irq, rxerr_irq, scl_oe, sda_oe;
    logic [7:0] rx_data;

    logic       stretch = 1'b0;
    logic       armed = 1'b0;
    logic [9:0] pull_seq = '0;
    int         pidx = 0;
    wire        slave_pull = armed && pull_seq[pidx];
    wire        scl_bus = !(scl_oe || stretch);
    wire        sda_bus = !(sda_oe || slave_pull);

    int         n_start = 0, n_stop = 0, nrec = 0;
    logic [15:0] rec = '0;
    int         checks = 0, failures = 0;
    logic [3:0] tdiv = '0;

    i2cm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .ack_nak(ack_nak),
        .lsb_first(lsb_first), .rx_read(rx_read), .busy(busy),
        .rx_data(rx_data), .rx_valid(rx_valid), .nak_seen(nak_seen),
        .done_irq(done_irq), .rxerr_irq(rxerr_irq), .scl_oe(scl_oe),
        .scl_in(scl_bus), .sda_oe(sda_oe), .sda_in(sda_bus)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 1'b1;
        tick <= (tdiv[1:0] == 2'd3);
    end

    always @(negedge sda_bus) if (scl_bus === 1'b1) n_start++;
    always @(posedge sda_bus) if (scl_bus === 1'b1) n_stop++;
    always @(posedge scl_bus) begin
        if (nrec < 16) rec[nrec] = sda_bus;
        nrec++;
    end
    always @(negedge scl_bus) if (armed && pidx < 9) pidx++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic a, input logic l);
        @(negedge clk);
        cmd_op = op; cmd_data = d; ack_nak = a; lsb_first = l; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got, output bit err);
        got = 0; err = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rxerr_irq) err = 1;
            if (done_irq) begin got = 1; break; end
        end
    endtask

    function automatic logic [7:0] flip(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic t_reset();
        check(scl_oe == 0 && sda_oe == 0, "R1 lines", {scl_oe, sda_oe}, 0);
        check(!busy && !rx_valid && !nak_seen && !done_irq && !rxerr_irq, "R1 flags",
              {busy, rx_valid, nak_seen, done_irq, rxerr_irq}, 0);
    endtask

    task automatic t_bad_op();
        bit got, err;
        int s0 = n_start, p0 = n_stop, r0 = nrec;
        issue(3'd6, 8'h00, 0, 0);
        check(!busy, "R10 op6 busy", busy, 0);
        issue(3'd0, 8'h00, 0, 0);
        check(!busy, "R10 op0 busy", busy, 0);
        repeat (60) @(negedge clk);
        check(n_start == s0 && n_stop == p0 && nrec == r0 && !done_irq, "R10 no bus activity",
              nrec - r0, 0);
    endtask

    task automatic t_start();
        bit got, err;
        int s0 = n_start;
        issue(3'd1, 8'h00, 0, 0);
        wait_done(got, err);
        check(got, "R2 done", got, 1);
        check(n_start == s0 + 1, "R2 start seen", n_start - s0, 1);
        check(scl_oe && sda_oe, "R2 both low after", {scl_oe, sda_oe}, 2'b11);
        @(negedge clk);
        check(!done_irq, "R2 single pulse", done_irq, 0);
    endtask

    task automatic t_write(input logic [7:0] d, input logic l, input logic slave_ack);
        bit got, err;
        logic [7:0] exp_wire;
        int s0 = n_start, p0 = n_stop;
        pull_seq = {1'b0, slave_ack, 8'h00}; pidx = 0; armed = 1'b1;
        nrec = 0;
        issue(3'd3, d, 0, l);
        wait_done(got, err);
        armed = 1'b0;
        exp_wire = l ? flip(d) : d;
        check(got && nrec == 9, "R5 nine clocks", nrec, 9);
        check(flip(rec[7:0]) == exp_wire, "R4 bit order", flip(rec[7:0]), exp_wire);
        check(n_start == s0 && n_stop == p0, "R4 no condition in byte", n_start - s0 + n_stop - p0, 0);
        check(nak_seen == !slave_ack, "R5 nak flag", nak_seen, !slave_ack);
    endtask

    task automatic t_read(input logic [7:0] d, input logic l, input bit expect_err);
        bit got, err;
        logic [7:0] wire_bits;
        wire_bits = l ? flip(d) : d;
        pull_seq = {2'b00, ~flip(wire_bits)}; pidx = 0; armed = 1'b1;
        nrec = 0;
        issue(3'd4, 8'h00, 0, l);
        wait_done(got, err);
        armed = 1'b0;
        check(got && nrec == 8, "R6 eight clocks", nrec, 8);
        check(rx_data == d, "R6 rx_data", rx_data, d);
        check(rx_valid, "R6 rx_valid", rx_valid, 1);
        check(err == expect_err, "R9 overrun pulse", err, expect_err);
    endtask

    task automatic t_ack(input logic v);
        bit got, err;
        nrec = 0;
        issue(3'd5, 8'h00, v, 0);
        wait_done(got, err);
        check(got && nrec == 1 && rec[0] == v, "R7 ack bit", rec[0], v);
    endtask

    task automatic t_stretch();
        bit got, err;
        nrec = 0;
        stretch = 1'b1;
        issue(3'd5, 8'h00, 0, 0);
        repeat (100) @(negedge clk);
        check(busy && nrec == 0 && !done_irq, "R8 held while stretched", busy, 1);
        stretch = 1'b0;
        wait_done(got, err);
        check(got && nrec == 1, "R8 resumes", nrec, 1);
    endtask

    task automatic t_busy_ignore();
        bit got, err;
        int p0 = n_stop, s0 = n_start;
        issue(3'd1, 8'h00, 0, 0);
        issue(3'd2, 8'h00, 0, 0);
        wait_done(got, err);
        repeat (80) @(negedge clk);
        check(got && n_stop == p0 && n_start == s0 + 1, "R10 stop ignored while busy",
              n_stop - p0, 0);
        check(!busy && sda_oe, "R10 still held", sda_oe, 1);
    endtask

    task automatic t_rx_read();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
        check(!rx_valid, "R9 read clears", rx_valid, 0);
    endtask

    task automatic t_stop();
        bit got, err;
        int p0 = n_stop;
        issue(3'd2, 8'h00, 0, 0);
        wait_done(got, err);
        check(got && n_stop == p0 + 1, "R3 stop seen", n_stop - p0, 1);
        check(!scl_oe && !sda_oe, "R3 released", {scl_oe, sda_oe}, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                repeat (2) @(negedge clk);
                t_reset();
                t_bad_op();
                t_start();
                t_write(8'hA5, 1'b0, 1'b1);
                t_write(8'h3C, 1'b1, 1'b0);
                t_busy_ignore();
                t_read(8'h96, 1'b0, 0);
                t_ack(1'b0);
                t_read(8'h4B, 1'b1, 1);
                t_rx_read();
                t_ack(1'b1);
                t_stretch();
                t_stop();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule